// File: doc/BRIEF.md
# Operand Bypass and Load Hazard Unit

This block sits beside the decode stage of a five-stage in-order pipeline. Decode names up to two source registers and reads them from the register file. A register file write only lands at the next clock edge. Younger results may also still be in flight in the execute, memory and write-back stages. The block therefore checks each source ID against every in-flight destination and replaces the register file value with the freshest in-flight result.

Each of the three later stages offers two result paths: an arithmetic result with its own destination, and a load result with its own destination. In execute, the load data does not exist yet. When a load in execute targets a register that decode needs, bypassing cannot help. The block then asserts a stall for fetch and decode and a bubble for execute. For the bubble, it replaces the control fields that would enter execute with a no-op and two empty destinations. On the next cycle the load sits in the memory stage, and its data is bypassed from there.

Register ID all-ones (0xF at the default width) means "no register". It never takes part in a match. The block is purely combinational. The clock and active-low reset are used only by the embedded property checks.

Top module: `fwd_stall_unit`

## Requirements
- R1: When a source ID matches no in-flight destination, its operand output equals the register file value supplied for it.
- R2: A write-back arithmetic result is bypassed when the write-back arithmetic destination matches the source ID and no younger producer matches.
- R3: A write-back load result is bypassed when the write-back load destination matches, and it takes priority over the write-back arithmetic result.
- R4: A memory-stage arithmetic result is bypassed when its destination matches, and it takes priority over both write-back results.
- R5: A memory-stage load result is bypassed when its destination matches, and it takes priority over the memory-stage arithmetic result and both write-back results.
- R6: The execute-stage arithmetic result is bypassed in the same cycle when its destination matches, and it takes priority over every other producer.
- R7: Stall and bubble are both 1 exactly when the execute-stage load destination is not the "none" ID (all ones) and equals at least one of the two source IDs. Otherwise both are 0.
- R8: The "none" ID (all ones) never matches. A source ID of all ones passes its register file value through regardless of any destination. A destination of all ones never bypasses and never stalls.
- R9: While bubble is 1, the outgoing execute opcode is the no-op code (default 0x1) and both outgoing destinations are all ones. While bubble is 0, the decode opcode and destinations pass through unchanged.
- R10: The two operands are resolved independently by the same rules, so each may take a different producer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rstN | input | 1 | Active-low reset that disables the property checks |
| decRegA | input | ID_W | First source register ID in decode |
| decRegB | input | ID_W | Second source register ID in decode |
| rfValA | input | DATA_W | Register file read value for the first source |
| rfValB | input | DATA_W | Register file read value for the second source |
| decOp | input | OP_W | Opcode of the instruction leaving decode |
| decAluDst | input | ID_W | Arithmetic destination of the instruction leaving decode |
| decLoadDst | input | ID_W | Load destination of the instruction leaving decode |
| exeAluDst | input | ID_W | Execute-stage arithmetic destination |
| exeAluRes | input | DATA_W | Execute-stage arithmetic result, computed this cycle |
| exeLoadDst | input | ID_W | Execute-stage load destination |
| memAluDst | input | ID_W | Memory-stage arithmetic destination |
| memAluRes | input | DATA_W | Memory-stage arithmetic result |
| memLoadDst | input | ID_W | Memory-stage load destination |
| memLoadData | input | DATA_W | Data read by the load in the memory stage |
| wbAluDst | input | ID_W | Write-back arithmetic destination |
| wbAluRes | input | DATA_W | Write-back arithmetic result |
| wbLoadDst | input | ID_W | Write-back load destination |
| wbLoadData | input | DATA_W | Write-back load data |
| opndA | output | DATA_W | Resolved first operand |
| opndB | output | DATA_W | Resolved second operand |
| stallFetchDec | output | 1 | Hold fetch and decode for one cycle |
| bubbleExe | output | 1 | Insert a no-op into execute |
| exeNextOp | output | OP_W | Opcode to load into the execute register |
| exeNextAluDst | output | ID_W | Arithmetic destination to load into the execute register |
| exeNextLoadDst | output | ID_W | Load destination to load into the execute register |

## Verification
Two things can happen in the same cycle: a load in execute can trip the stall, and other producers can match the same or the other source at the same time. A further case is a single source that several producers match at once, so that the priority order alone decides the result. The bench provokes all of these together. It sweeps every assignment of each of the six destinations among a matching ID, a non-matching ID and "none", against every pair of source IDs drawn from the same three values. For each vector it computes the winning producer, the stall and the bubbled control fields arithmetically, and compares them with the outputs.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // producers in priority order: 0 = youngest
  localparam int SRC_N = 5;
  localparam int P_EXE_ALU  = 0;
  localparam int P_MEM_LOAD = 1;
  localparam int P_MEM_ALU  = 2;
  localparam int P_WB_LOAD  = 3;
  localparam int P_WB_ALU   = 4;

  typedef struct packed {
    logic [SRC_N-1:0] selA;
    logic [SRC_N-1:0] selB;
    logic             stall;
    logic             bubble;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] decRegA,
  input  logic [ID_W-1:0] decRegB,
  input  logic [ID_W-1:0] exeAluDst,
  input  logic [ID_W-1:0] exeLoadDst,
  input  logic [ID_W-1:0] memAluDst,
  input  logic [ID_W-1:0] memLoadDst,
  input  logic [ID_W-1:0] wbAluDst,
  input  logic [ID_W-1:0] wbLoadDst,
  output fwdStrobes_t     strobes
);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  logic [ID_W-1:0]  prodDst [SRC_N];
  logic [ID_W-1:0]  srcReg  [2];
  logic [SRC_N-1:0] sel     [2];

  always_comb begin
    prodDst[P_EXE_ALU]  = exeAluDst;
    prodDst[P_MEM_LOAD] = memLoadDst;
    prodDst[P_MEM_ALU]  = memAluDst;
    prodDst[P_WB_LOAD]  = wbLoadDst;
    prodDst[P_WB_ALU]   = wbAluDst;
    srcReg[0] = decRegA;
    srcReg[1] = decRegB;
  end

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    logic [SRC_N-1:0] hit;
    always_comb begin
      for (int j = 0; j < SRC_N; j++) begin
        hit[j] = (srcReg[k] != NONE_ID) && (prodDst[j] == srcReg[k]);
      end
      // keep lowest set bit: youngest producer wins
      sel[k] = hit & (~hit + SRC_N'(1));
    end

    // R10: at most one producer drives each operand
    a_r10_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(sel[k]));
    // R6: an execute match always takes the operand
    a_r6_exe_wins: assert property (@(posedge clk) disable iff (!rstN)
      (srcReg[k] != NONE_ID && exeAluDst == srcReg[k]) |-> sel[k][P_EXE_ALU]);
  end

  logic loadHit;
  always_comb begin
    loadHit = (exeLoadDst != NONE_ID) &&
              ((exeLoadDst == decRegA) || (exeLoadDst == decRegB));
    strobes.selA   = sel[0];
    strobes.selB   = sel[1];
    strobes.stall  = loadHit;
    strobes.bubble = loadHit;
  end

  // R8: a none source never selects a producer
  a_r8_none_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (decRegA == NONE_ID) |-> (strobes.selA == '0));
endmodule

// File: rtl/fwd_dpath.sv
module fwd_dpath
  import fwd_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              ID_W   = 4,
  parameter int              OP_W   = 4,
  parameter logic [OP_W-1:0] NOP_OP = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] rfValA,
  input  logic [DATA_W-1:0] rfValB,
  input  logic [DATA_W-1:0] exeAluRes,
  input  logic [DATA_W-1:0] memLoadData,
  input  logic [DATA_W-1:0] memAluRes,
  input  logic [DATA_W-1:0] wbLoadData,
  input  logic [DATA_W-1:0] wbAluRes,
  input  logic [OP_W-1:0]   decOp,
  input  logic [ID_W-1:0]   decAluDst,
  input  logic [ID_W-1:0]   decLoadDst,
  output logic [DATA_W-1:0] opndA,
  output logic [DATA_W-1:0] opndB,
  output logic [OP_W-1:0]   exeNextOp,
  output logic [ID_W-1:0]   exeNextAluDst,
  output logic [ID_W-1:0]   exeNextLoadDst
);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  logic [DATA_W-1:0] prodVal [SRC_N];
  logic [DATA_W-1:0] rfVal   [2];
  logic [SRC_N-1:0]  sel     [2];
  logic [DATA_W-1:0] opVal   [2];

  always_comb begin
    prodVal[P_EXE_ALU]  = exeAluRes;
    prodVal[P_MEM_LOAD] = memLoadData;
    prodVal[P_MEM_ALU]  = memAluRes;
    prodVal[P_WB_LOAD]  = wbLoadData;
    prodVal[P_WB_ALU]   = wbAluRes;
    rfVal[0] = rfValA;
    rfVal[1] = rfValB;
    sel[0]   = strobes.selA;
    sel[1]   = strobes.selB;
  end

  for (genvar k = 0; k < 2; k++) begin : g_mux
    always_comb begin
      opVal[k] = (sel[k] == '0) ? rfVal[k] : '0;
      for (int j = 0; j < SRC_N; j++) begin
        opVal[k] = opVal[k] | ({DATA_W{sel[k][j]}} & prodVal[j]);
      end
    end

    // R1: no selection passes the register file value
    a_r1_rf_pass: assert property (@(posedge clk) disable iff (!rstN)
      (sel[k] == '0) |-> (opVal[k] == rfVal[k]));
  end

  assign opndA = opVal[0];
  assign opndB = opVal[1];

  always_comb begin
    if (strobes.bubble) begin
      exeNextOp      = NOP_OP;
      exeNextAluDst  = NONE_ID;
      exeNextLoadDst = NONE_ID;
    end else begin
      exeNextOp      = decOp;
      exeNextAluDst  = decAluDst;
      exeNextLoadDst = decLoadDst;
    end
  end

  // R9: a bubble carries no destination
  a_r9_bubble_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bubble |-> (exeNextAluDst == NONE_ID && exeNextLoadDst == NONE_ID));
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import fwd_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              ID_W   = 4,
  parameter int              OP_W   = 4,
  parameter logic [OP_W-1:0] NOP_OP = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   decRegA,
  input  logic [ID_W-1:0]   decRegB,
  input  logic [DATA_W-1:0] rfValA,
  input  logic [DATA_W-1:0] rfValB,
  input  logic [OP_W-1:0]   decOp,
  input  logic [ID_W-1:0]   decAluDst,
  input  logic [ID_W-1:0]   decLoadDst,
  input  logic [ID_W-1:0]   exeAluDst,
  input  logic [DATA_W-1:0] exeAluRes,
  input  logic [ID_W-1:0]   exeLoadDst,
  input  logic [ID_W-1:0]   memAluDst,
  input  logic [DATA_W-1:0] memAluRes,
  input  logic [ID_W-1:0]   memLoadDst,
  input  logic [DATA_W-1:0] memLoadData,
  input  logic [ID_W-1:0]   wbAluDst,
  input  logic [DATA_W-1:0] wbAluRes,
  input  logic [ID_W-1:0]   wbLoadDst,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [DATA_W-1:0] opndA,
  output logic [DATA_W-1:0] opndB,
  output logic              stallFetchDec,
  output logic              bubbleExe,
  output logic [OP_W-1:0]   exeNextOp,
  output logic [ID_W-1:0]   exeNextAluDst,
  output logic [ID_W-1:0]   exeNextLoadDst
);
  fwdStrobes_t strobes;

  fwd_ctrl #(.ID_W(ID_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .decRegA(decRegA), .decRegB(decRegB),
    .exeAluDst(exeAluDst), .exeLoadDst(exeLoadDst),
    .memAluDst(memAluDst), .memLoadDst(memLoadDst),
    .wbAluDst(wbAluDst), .wbLoadDst(wbLoadDst),
    .strobes(strobes)
  );

  fwd_dpath #(.DATA_W(DATA_W), .ID_W(ID_W), .OP_W(OP_W), .NOP_OP(NOP_OP)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rfValA(rfValA), .rfValB(rfValB),
    .exeAluRes(exeAluRes), .memLoadData(memLoadData), .memAluRes(memAluRes),
    .wbLoadData(wbLoadData), .wbAluRes(wbAluRes),
    .decOp(decOp), .decAluDst(decAluDst), .decLoadDst(decLoadDst),
    .opndA(opndA), .opndB(opndB),
    .exeNextOp(exeNextOp), .exeNextAluDst(exeNextAluDst),
    .exeNextLoadDst(exeNextLoadDst)
  );

  assign stallFetchDec = strobes.stall;
  assign bubbleExe     = strobes.bubble;

  // R7: stall and bubble always travel together, and need a live load match
  a_r7_stall_pair: assert property (@(posedge clk) disable iff (!rstN)
    stallFetchDec == bubbleExe);
  a_r7_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    stallFetchDec |-> (exeLoadDst != {ID_W{1'b1}} &&
                       (exeLoadDst == decRegA || exeLoadDst == decRegB)));
  // R9: bubble forces the no-op code
  a_r9_bubble_nop: assert property (@(posedge clk) disable iff (!rstN)
    bubbleExe |-> (exeNextOp == NOP_OP));
endmodule

// File: tb/test_fwd_stall_unit.sv
`timescale 1ns/1ps
module test_fwd_stall_unit;
  localparam int DW = 16;
  localparam int IW = 4;
  localparam int OW = 4;
  localparam logic [IW-1:0] NONE = 4'hF;
  localparam logic [OW-1:0] NOPC = 4'h1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [IW-1:0] decRegA, decRegB, decAluDst, decLoadDst;
  logic [IW-1:0] exeAluDst, exeLoadDst, memAluDst, memLoadDst, wbAluDst, wbLoadDst;
  logic [DW-1:0] rfValA, rfValB, exeAluRes, memAluRes, memLoadData, wbAluRes, wbLoadData;
  logic [OW-1:0] decOp;
  logic [DW-1:0] opndA, opndB;
  logic          stallFetchDec, bubbleExe;
  logic [OW-1:0] exeNextOp;
  logic [IW-1:0] exeNextAluDst, exeNextLoadDst;

  fwd_stall_unit i_fwd_stall_unit (
    .clk(clk), .rstN(rstN),
    .decRegA(decRegA), .decRegB(decRegB), .rfValA(rfValA), .rfValB(rfValB),
    .decOp(decOp), .decAluDst(decAluDst), .decLoadDst(decLoadDst),
    .exeAluDst(exeAluDst), .exeAluRes(exeAluRes), .exeLoadDst(exeLoadDst),
    .memAluDst(memAluDst), .memAluRes(memAluRes),
    .memLoadDst(memLoadDst), .memLoadData(memLoadData),
    .wbAluDst(wbAluDst), .wbAluRes(wbAluRes),
    .wbLoadDst(wbLoadDst), .wbLoadData(wbLoadData),
    .opndA(opndA), .opndB(opndB),
    .stallFetchDec(stallFetchDec), .bubbleExe(bubbleExe),
    .exeNextOp(exeNextOp), .exeNextAluDst(exeNextAluDst),
    .exeNextLoadDst(exeNextLoadDst)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference operand: returns value and requirement tag of the winner
  function automatic logic [DW-1:0] refOpnd(input logic [IW-1:0] src,
                                            input logic [DW-1:0] rf,
                                            output string tag);
    if (src == NONE) begin tag = "R8"; return rf; end
    if (exeAluDst  == src) begin tag = "R6"; return exeAluRes;   end
    if (memLoadDst == src) begin tag = "R5"; return memLoadData; end
    if (memAluDst  == src) begin tag = "R4"; return memAluRes;   end
    if (wbLoadDst  == src) begin tag = "R3"; return wbLoadData;  end
    if (wbAluDst   == src) begin tag = "R2"; return wbAluRes;    end
    tag = "R1";
    return rf;
  endfunction

  task automatic checkAll();
    string tA, tB;
    logic [DW-1:0] eA, eB;
    logic eStall;
    eA = refOpnd(decRegA, rfValA, tA);
    eB = refOpnd(decRegB, rfValB, tB);
    eStall = (exeLoadDst != NONE) && (exeLoadDst == decRegA || exeLoadDst == decRegB);
    chk({tA, " R10 opndA"}, 32'(opndA), 32'(eA));
    chk({tB, " R10 opndB"}, 32'(opndB), 32'(eB));
    chk("R7 stall", 32'(stallFetchDec), 32'(eStall));
    chk("R7 bubble", 32'(bubbleExe), 32'(eStall));
    chk("R9 op", 32'(exeNextOp), eStall ? 32'(NOPC) : 32'(decOp));
    chk("R9 dsts", {exeNextAluDst, exeNextLoadDst},
        eStall ? {NONE, NONE} : {decAluDst, decLoadDst});
  endtask

  initial begin
    logic [IW-1:0] cand [3];
    cand[0] = 4'h2; cand[1] = 4'h5; cand[2] = NONE;
    rfValA = 16'hA0A0; rfValB = 16'hB0B0;
    exeAluRes = 16'h1111; memLoadData = 16'h2222; memAluRes = 16'h3333;
    wbLoadData = 16'h4444; wbAluRes = 16'h5555;
    decOp = 4'h6; decAluDst = 4'h3; decLoadDst = 4'h4;
    decRegA = NONE; decRegB = NONE;
    exeAluDst = NONE; exeLoadDst = NONE; memAluDst = NONE;
    memLoadDst = NONE; wbAluDst = NONE; wbLoadDst = NONE;
    // reset state: nothing in flight
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset opndA", 32'(opndA), 32'(rfValA));
    chk("R1 reset opndB", 32'(opndB), 32'(rfValB));
    chk("R7 reset stall", 32'(stallFetchDec), 32'd0);
    chk("R9 reset op", 32'(exeNextOp), 32'(decOp));
    rstN = 1'b1;
    // sweep: sources and all six destinations over {match 2, other 5, none}
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int e0 = 0; e0 < 3; e0++)
          for (int e1 = 0; e1 < 3; e1++)
            for (int m0 = 0; m0 < 3; m0++)
              for (int m1 = 0; m1 < 3; m1++)
                for (int w0 = 0; w0 < 3; w0++)
                  for (int w1 = 0; w1 < 3; w1++) begin
                    @(negedge clk);
                    decRegA = cand[a];  decRegB = cand[b];
                    exeAluDst = cand[e0]; exeLoadDst = cand[e1];
                    memAluDst = cand[m0]; memLoadDst = cand[m1];
                    wbAluDst = cand[w0];  wbLoadDst = cand[w1];
                    #1;
                    checkAll();
                  end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule